// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer reached through a small 32-bit register port (write strobe, byte address, write data, combinational read data). A free-running tick input from a slow clock domain advances a counter. When the counter reaches a programmed limit, the block raises a reset-request output. That output stays high until the block itself is reset. Software keeps the counter from reaching the limit by writing a refresh key to the counter register. Before it can change the configuration, software must write an unlock key to the same register. This opens a short configuration window. Each key is accepted either as one 32-bit word or as two 16-bit halves written one after the other. A mode bit in the control word selects which of the two forms applies.

Three state machines make up the block:
- **Key detector**: states `KEY_IDLE`, `KEY_UNL_HALF` and `KEY_REF_HALF`. A matching first half moves `KEY_IDLE` to a half state. The next write of any kind returns a half state to `KEY_IDLE`, and that write completes the key only if it is the matching second half.
- **Configuration guard**: states `CFG_LOCKED`, `CFG_OPEN` and `CFG_SEALED`. An unlock moves `CFG_LOCKED` to `CFG_OPEN`. `CFG_OPEN` returns to `CFG_LOCKED` when its window runs out, and after a configuration write. If that write leaves the update-permit bit clear, `CFG_OPEN` moves to `CFG_SEALED` instead. Only reset leaves `CFG_SEALED`.
- **Counter**: states `CNT_HOLD`, `CNT_RUN` and `CNT_FIRED`. Setting the enable bit moves `CNT_HOLD` to `CNT_RUN`, and clearing it moves `CNT_RUN` back to `CNT_HOLD`. A count at or above the limit moves `CNT_RUN` to `CNT_FIRED`, which is final.

The clock-source select field is stored and read back only. The tick is always the `tick_i` input.

Top module: `kwd_top`

## Requirements
- R1: After reset the control word reads 0x0000_0020 (only the update-permit bit set), the counter reads 0, the timeout reads `RST_TOVAL`, and `wdog_rst_o` is 0.
- R2: Offset 0x0 is the control word, 0x4 the counter and 0x8 the timeout; any other offset reads 0. Control bit positions: 13 word-key mode, 11 unlocked (read-only), 10 reconfiguration done (read-only), 9:8 clock select, 7 enable, 5 update permit. All other bits read 0.
- R3: In word-key mode, writing 0xB480A602 to the counter clears the count at the edge that samples the write.
- R4: In word-key mode, writing 0xD928C520 to the counter opens the configuration window, and bit 11 reads 1.
- R5: With word-key mode off, writing 0xC520 and then 0xD928 (low 16 bits) to the counter as two consecutive writes opens the window.
- R6: With word-key mode off, writing 0xA602 and then 0xB480 to the counter as two consecutive writes clears the count.
- R7: A wrong second half, or any other write between the two halves, aborts the sequence, and neither unlock nor refresh follows.
- R8: Writes to the control word or the timeout while the window is closed change nothing.
- R9: The window closes after `WIN_CYCLES` clock cycles, or after one accepted configuration write, whichever comes first.
- R10: Bit 10 reads 1 from the second cycle after an accepted configuration write, and it clears when a new unlock opens the window.
- R11: Once a configuration write leaves the update-permit bit at 0, further unlock keys are refused and the configuration stays fixed until reset.
- R12: While enabled and not expired, each cycle with `tick_i` high adds one to the count. While disabled, the count holds. The count is readable at 0x4.
- R13: When an enabled count reaches the timeout value, `wdog_rst_o` rises one cycle later. It stays high until reset, and the count stops.
- R14: In word-key mode the 16-bit half keys have no effect. A word unlock followed by a control write with bit 13 clear returns the block to half-key mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and state clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count tick, one cycle wide per tick |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte address |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i` (combinational) |
| wdog_rst_o | output | 1 | Reset request, held once asserted |

## Verification
The following results appear after the rising edge that samples the write or tick: register writes, completed keys and count changes. They are therefore due one cycle after the stimulus. The reconfiguration-done flag is due one cycle later than that. The reset request rises one edge after the count reaches the limit. The window expires `WIN_CYCLES` edges after the unlock. The bench drives and samples only on falling edges. It reads each result in the first falling edge at which it is due. For the two delayed results, it also samples the falling edge just before and expects the old value there.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;

    // register offsets (byte addresses)
    localparam int unsigned OFS_CS  = 32'h0;
    localparam int unsigned OFS_CNT = 32'h4;
    localparam int unsigned OFS_TOV = 32'h8;

    // keys written to the counter register
    localparam logic [31:0] KEY_REF_WORD = 32'hB480_A602;
    localparam logic [31:0] KEY_UNL_WORD = 32'hD928_C520;
    localparam logic [15:0] KEY_UNL_LO   = 16'hC520;
    localparam logic [15:0] KEY_UNL_HI   = 16'hD928;
    localparam logic [15:0] KEY_REF_LO   = 16'hA602;
    localparam logic [15:0] KEY_REF_HI   = 16'hB480;

    // control word bit positions
    localparam int unsigned CSB_WORD  = 13;
    localparam int unsigned CSB_UNLK  = 11;
    localparam int unsigned CSB_DONE  = 10;
    localparam int unsigned CSB_CLKLO = 8;
    localparam int unsigned CSB_EN    = 7;
    localparam int unsigned CSB_UPD   = 5;

    typedef enum logic [1:0] {
        KEY_IDLE,
        KEY_UNL_HALF,
        KEY_REF_HALF
    } key_st_e;

    typedef enum logic [1:0] {
        CFG_LOCKED,
        CFG_OPEN,
        CFG_SEALED
    } cfg_st_e;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_RUN,
        CNT_FIRED
    } cnt_st_e;

    typedef struct packed {
        logic       word_mode;
        logic [1:0] clk_sel;
        logic       enable;
        logic       upd_ok;
    } cfg_t;

endpackage

// File: rtl/kwd_keyseq.sv
`timescale 1ns/1ps
module kwd_keyseq
    import kwd_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_en_i,
    input  logic        hit_cnt_i,
    input  logic [31:0] wr_data_i,
    input  logic        word_mode_i,
    output logic        unlock_o,
    output logic        refresh_o
);

    key_st_e     key_q;
    key_st_e     key_nxt;
    logic        wr_key;
    logic [15:0] half;

    assign wr_key = wr_en_i && hit_cnt_i;
    assign half   = wr_data_i[15:0];

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            key_q <= KEY_IDLE;
        end else begin
            key_q <= key_nxt;
        end
    end

    // next state
    always_comb begin
        key_nxt = key_q;
        unique case (key_q)
            KEY_IDLE: begin
                if (wr_key && !word_mode_i) begin
                    if (half == KEY_UNL_LO) begin
                        key_nxt = KEY_UNL_HALF;
                    end else if (half == KEY_REF_LO) begin
                        key_nxt = KEY_REF_HALF;
                    end
                end
            end
            KEY_UNL_HALF, KEY_REF_HALF: begin
                // any write ends a pending half sequence
                if (wr_en_i) begin
                    key_nxt = KEY_IDLE;
                end
            end
            default: key_nxt = KEY_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unlock_o  = 1'b0;
        refresh_o = 1'b0;
        unique case (key_q)
            KEY_IDLE: begin
                if (wr_key && word_mode_i) begin
                    unlock_o  = (wr_data_i == KEY_UNL_WORD);
                    refresh_o = (wr_data_i == KEY_REF_WORD);
                end
            end
            KEY_UNL_HALF: unlock_o  = wr_key && !word_mode_i && (half == KEY_UNL_HI);
            KEY_REF_HALF: refresh_o = wr_key && !word_mode_i && (half == KEY_REF_HI);
            default: begin
                unlock_o  = 1'b0;
                refresh_o = 1'b0;
            end
        endcase
    end

    // R7: a pending half key never survives the next write
    a_r7_half_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (key_q != KEY_IDLE && wr_en_i) |=> (key_q == KEY_IDLE));

    // R14: in word-key mode no half sequence starts
    a_r14_word_no_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_mode_i && key_q == KEY_IDLE) |=> (key_q == KEY_IDLE));

endmodule

// File: rtl/kwd_cfg.sv
`timescale 1ns/1ps
module kwd_cfg
    import kwd_pkg::*;
#(
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned WIN_CYCLES = 256,
    parameter int unsigned RST_TOVAL  = 60000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic             hit_cs_i,
    input  logic             hit_tov_i,
    input  logic [31:0]      wr_data_i,
    input  logic             unlock_i,
    output cfg_t             cfg_o,
    output logic [CNT_W-1:0] toval_o,
    output logic             unlocked_o,
    output logic             done_o
);

    localparam int unsigned WIN_W = $clog2(WIN_CYCLES + 1);

    cfg_st_e          st_q;
    cfg_st_e          st_nxt;
    logic [WIN_W-1:0] win_q;
    cfg_t             cfg_q;
    logic [CNT_W-1:0] tov_q;
    logic             pend_q;
    logic             done_q;
    logic             cfg_wr;
    logic             open_evt;
    logic             upd_after;

    assign cfg_wr    = (st_q == CFG_OPEN) && wr_en_i && (hit_cs_i || hit_tov_i);
    assign open_evt  = unlock_i && (st_q != CFG_SEALED);
    assign upd_after = hit_cs_i ? wr_data_i[CSB_UPD] : cfg_q.upd_ok;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= CFG_LOCKED;
        end else begin
            st_q <= st_nxt;
        end
    end

    // next state
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            CFG_LOCKED: begin
                if (unlock_i) st_nxt = CFG_OPEN;
            end
            CFG_OPEN: begin
                if (cfg_wr) begin
                    st_nxt = upd_after ? CFG_LOCKED : CFG_SEALED;
                end else if (unlock_i) begin
                    st_nxt = CFG_OPEN;
                end else if (win_q == '0) begin
                    st_nxt = CFG_LOCKED;
                end
            end
            CFG_SEALED: st_nxt = CFG_SEALED;
            default:    st_nxt = CFG_LOCKED;
        endcase
    end

    // window timer
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            win_q <= '0;
        end else if (open_evt) begin
            win_q <= WIN_W'(WIN_CYCLES - 1);
        end else if (st_q == CFG_OPEN && win_q != '0) begin
            win_q <= win_q - 1'b1;
        end
    end

    // configuration registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.word_mode <= 1'b0;
            cfg_q.clk_sel   <= 2'b00;
            cfg_q.enable    <= 1'b0;
            cfg_q.upd_ok    <= 1'b1;
            tov_q           <= CNT_W'(RST_TOVAL);
        end else if (cfg_wr) begin
            if (hit_cs_i) begin
                cfg_q.word_mode <= wr_data_i[CSB_WORD];
                cfg_q.clk_sel   <= wr_data_i[CSB_CLKLO +: 2];
                cfg_q.enable    <= wr_data_i[CSB_EN];
                cfg_q.upd_ok    <= wr_data_i[CSB_UPD];
            end
            if (hit_tov_i) begin
                tov_q <= wr_data_i[CNT_W-1:0];
            end
        end
    end

    // reconfiguration-done flag, one cycle behind the accepted write
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            pend_q <= cfg_wr;
            if (open_evt) begin
                done_q <= 1'b0;
            end else if (pend_q) begin
                done_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cfg_o      = cfg_q;
        toval_o    = tov_q;
        unlocked_o = (st_q == CFG_OPEN);
        done_o     = done_q;
    end

    // R8: the timeout cannot change while the window is closed
    a_r8_tov_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q != CFG_OPEN) |=> $stable(tov_q));

    // R9: an accepted configuration write closes the window
    a_r9_write_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_wr |=> (st_q != CFG_OPEN));

    // R10: a new unlock clears the done flag
    a_r10_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        open_evt |=> !done_q);

    // R11: a sealed configuration stays sealed
    a_r11_sealed_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == CFG_SEALED) |=> (st_q == CFG_SEALED) && $stable(cfg_q));

endmodule

// File: rtl/kwd_counter.sv
`timescale 1ns/1ps
module kwd_counter
    import kwd_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             enable_i,
    input  logic             refresh_i,
    input  logic [CNT_W-1:0] toval_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fired_o
);

    cnt_st_e          st_q;
    cnt_st_e          st_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             reached;

    assign reached = (cnt_q >= toval_i);

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= CNT_HOLD;
        end else begin
            st_q <= st_nxt;
        end
    end

    // next state
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            CNT_HOLD: begin
                if (enable_i) st_nxt = CNT_RUN;
            end
            CNT_RUN: begin
                if (reached) begin
                    st_nxt = CNT_FIRED;
                end else if (!enable_i) begin
                    st_nxt = CNT_HOLD;
                end
            end
            CNT_FIRED: st_nxt = CNT_FIRED;
            default:   st_nxt = CNT_HOLD;
        endcase
    end

    // count register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (st_q != CNT_FIRED) begin
            if (refresh_i) begin
                cnt_q <= '0;
            end else if (st_q == CNT_RUN && tick_i && !reached) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cnt_o   = cnt_q;
        fired_o = (st_q == CNT_FIRED);
    end

    // R13: the reset request holds once raised
    a_r13_fired_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fired_o |=> fired_o && $stable(cnt_q));

    // R3: a refresh before expiry clears the count
    a_r3_refresh_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (refresh_i && st_q != CNT_FIRED) |=> (cnt_q == '0));

    // R12: a disabled counter only changes on refresh
    a_r12_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == CNT_HOLD && !refresh_i) |=> $stable(cnt_q));

endmodule

// File: rtl/kwd_top.sv
`timescale 1ns/1ps
module kwd_top
    import kwd_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned WIN_CYCLES = 256,
    parameter int unsigned RST_TOVAL  = 60000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wr_data_i,
    output logic [31:0]       rd_data_o,
    output logic              wdog_rst_o
);

    logic             hit_cs;
    logic             hit_cnt;
    logic             hit_tov;
    logic             unlock;
    logic             refresh;
    cfg_t             cfg;
    logic [CNT_W-1:0] toval;
    logic [CNT_W-1:0] cnt;
    logic             unlocked;
    logic             done;
    logic             fired;
    logic [31:0]      cs_word;

    assign hit_cs  = (addr_i == ADDR_W'(OFS_CS));
    assign hit_cnt = (addr_i == ADDR_W'(OFS_CNT));
    assign hit_tov = (addr_i == ADDR_W'(OFS_TOV));

    kwd_keyseq u_keyseq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en_i),
        .hit_cnt_i   (hit_cnt),
        .wr_data_i   (wr_data_i),
        .word_mode_i (cfg.word_mode),
        .unlock_o    (unlock),
        .refresh_o   (refresh)
    );

    kwd_cfg #(
        .CNT_W      (CNT_W),
        .WIN_CYCLES (WIN_CYCLES),
        .RST_TOVAL  (RST_TOVAL)
    ) u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .hit_cs_i   (hit_cs),
        .hit_tov_i  (hit_tov),
        .wr_data_i  (wr_data_i),
        .unlock_i   (unlock),
        .cfg_o      (cfg),
        .toval_o    (toval),
        .unlocked_o (unlocked),
        .done_o     (done)
    );

    kwd_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .enable_i  (cfg.enable),
        .refresh_i (refresh),
        .toval_i   (toval),
        .cnt_o     (cnt),
        .fired_o   (fired)
    );

    // control word assembly
    always_comb begin
        cs_word                 = '0;
        cs_word[CSB_WORD]       = cfg.word_mode;
        cs_word[CSB_UNLK]       = unlocked;
        cs_word[CSB_DONE]       = done;
        cs_word[CSB_CLKLO +: 2] = cfg.clk_sel;
        cs_word[CSB_EN]         = cfg.enable;
        cs_word[CSB_UPD]        = cfg.upd_ok;
    end

    // read mux
    always_comb begin
        rd_data_o = '0;
        if (hit_cs) begin
            rd_data_o = cs_word;
        end else if (hit_cnt) begin
            rd_data_o = 32'(cnt);
        end else if (hit_tov) begin
            rd_data_o = 32'(toval);
        end
    end

    assign wdog_rst_o = fired;

    // R4: the unlocked flag only rises after an unlock key
    a_r4_unlock_needs_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!unlocked && !unlock) |=> !unlocked);

    // R1: the reset request never rises while the counter is disabled and idle
    a_r1_no_spurious_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fired && !cfg.enable) |=> !fired);

endmodule

// File: tb/kwd_top_bench.sv
`timescale 1ns/1ps
module kwd_top_bench;

    localparam int unsigned WIN = 16;
    localparam int unsigned RTV = 60000;

    localparam logic [1:0] OP_WR   = 2'd0;
    localparam logic [1:0] OP_RD   = 2'd1;
    localparam logic [1:0] OP_TICK = 2'd2;
    localparam logic [1:0] OP_IDLE = 2'd3;

    // {op, addr, data, expected, requirement}
    localparam int NV = 54;
    localparam logic [73:0] VEC [NV] = '{
        {OP_RD,   4'h0, 32'h0,         32'h0000_0020, 4'd1},  // R1
        {OP_RD,   4'h4, 32'h0,         32'h0000_0000, 4'd1},  // R1
        {OP_RD,   4'h8, 32'h0,         32'h0000_EA60, 4'd1},  // R1
        {OP_RD,   4'hC, 32'h0,         32'h0000_0000, 4'd2},  // R2
        {OP_WR,   4'h4, 32'h0000_C520, 32'h0,         4'd5},  // R5
        {OP_WR,   4'h4, 32'h0000_D928, 32'h0,         4'd5},  // R5
        {OP_RD,   4'h0, 32'h0,         32'h0000_0820, 4'd5},  // R5
        {OP_WR,   4'h8, 32'h0000_0005, 32'h0,         4'd9},  // R9
        {OP_RD,   4'h8, 32'h0,         32'h0000_0005, 4'd9},  // R9
        {OP_RD,   4'h0, 32'h0,         32'h0000_0420, 4'd10}, // R10
        {OP_WR,   4'h8, 32'h0000_0007, 32'h0,         4'd8},  // R8
        {OP_RD,   4'h8, 32'h0,         32'h0000_0005, 4'd8},  // R8
        {OP_WR,   4'h4, 32'h0000_C520, 32'h0,         4'd5},  // R5
        {OP_WR,   4'h4, 32'h0000_D928, 32'h0,         4'd5},  // R5
        {OP_RD,   4'h0, 32'h0,         32'h0000_0820, 4'd10}, // R10
        {OP_WR,   4'h0, 32'h0000_21A0, 32'h0,         4'd2},  // R2
        {OP_RD,   4'h0, 32'h0,         32'h0000_25A0, 4'd2},  // R2
        {OP_TICK, 4'h0, 32'd3,         32'h0,         4'd12}, // R12
        {OP_RD,   4'h4, 32'h0,         32'd3,         4'd12}, // R12
        {OP_WR,   4'h4, 32'h0000_A602, 32'h0,         4'd14}, // R14
        {OP_WR,   4'h4, 32'h0000_B480, 32'h0,         4'd14}, // R14
        {OP_RD,   4'h4, 32'h0,         32'd3,         4'd14}, // R14
        {OP_WR,   4'h4, 32'hB480_A602, 32'h0,         4'd3},  // R3
        {OP_RD,   4'h4, 32'h0,         32'd0,         4'd3},  // R3
        {OP_TICK, 4'h0, 32'd2,         32'h0,         4'd12}, // R12
        {OP_RD,   4'h4, 32'h0,         32'd2,         4'd12}, // R12
        {OP_WR,   4'h4, 32'hD928_C520, 32'h0,         4'd4},  // R4
        {OP_RD,   4'h0, 32'h0,         32'h0000_29A0, 4'd4},  // R4
        {OP_IDLE, 4'h0, 32'd20,        32'h0,         4'd9},  // R9
        {OP_RD,   4'h0, 32'h0,         32'h0000_21A0, 4'd9},  // R9
        {OP_WR,   4'h0, 32'h0000_2120, 32'h0,         4'd8},  // R8
        {OP_RD,   4'h0, 32'h0,         32'h0000_21A0, 4'd8},  // R8
        {OP_RD,   4'h4, 32'h0,         32'd2,         4'd8},  // R8
        {OP_WR,   4'h4, 32'hD928_C520, 32'h0,         4'd14}, // R14
        {OP_WR,   4'h0, 32'h0000_01A0, 32'h0,         4'd14}, // R14
        {OP_RD,   4'h0, 32'h0,         32'h0000_05A0, 4'd14}, // R14
        {OP_WR,   4'h4, 32'h0000_C520, 32'h0,         4'd7},  // R7
        {OP_WR,   4'h4, 32'h0000_1234, 32'h0,         4'd7},  // R7
        {OP_WR,   4'h4, 32'h0000_D928, 32'h0,         4'd7},  // R7
        {OP_RD,   4'h0, 32'h0,         32'h0000_05A0, 4'd7},  // R7
        {OP_WR,   4'h4, 32'h0000_C520, 32'h0,         4'd7},  // R7
        {OP_WR,   4'h8, 32'h0000_0009, 32'h0,         4'd7},  // R7
        {OP_WR,   4'h4, 32'h0000_D928, 32'h0,         4'd7},  // R7
        {OP_RD,   4'h0, 32'h0,         32'h0000_05A0, 4'd7},  // R7
        {OP_RD,   4'h8, 32'h0,         32'd5,         4'd7},  // R7
        {OP_TICK, 4'h0, 32'd1,         32'h0,         4'd12}, // R12
        {OP_RD,   4'h4, 32'h0,         32'd3,         4'd12}, // R12
        {OP_WR,   4'h4, 32'h0000_A602, 32'h0,         4'd7},  // R7
        {OP_WR,   4'h4, 32'h0000_B481, 32'h0,         4'd7},  // R7
        {OP_WR,   4'h4, 32'h0000_B480, 32'h0,         4'd7},  // R7
        {OP_RD,   4'h4, 32'h0,         32'd3,         4'd7},  // R7
        {OP_WR,   4'h4, 32'h0000_A602, 32'h0,         4'd6},  // R6
        {OP_WR,   4'h4, 32'h0000_B480, 32'h0,         4'd6},  // R6
        {OP_RD,   4'h4, 32'h0,         32'd0,         4'd6}   // R6
    };

    logic        clk;
    logic        rst_n;
    logic        tick;
    logic        wr_en;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        wrst;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    kwd_top #(
        .ADDR_W     (4),
        .CNT_W      (32),
        .WIN_CYCLES (WIN),
        .RST_TOVAL  (RTV)
    ) u_kwd_top (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tick_i     (tick),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wr_data_i  (wdata),
        .rd_data_o  (rdata),
        .wdog_rst_o (wrst)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input int req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input int req);
        @(negedge clk);
        addr = a;
        #1;
        check(rdata == exp, req, rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic unlock16();
        wr(4'h4, 32'h0000_C520);
        wr(4'h4, 32'h0000_D928);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=still running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [73:0] v;
        rst_n = 1'b0;
        tick  = 1'b0;
        wr_en = 1'b0;
        addr  = '0;
        wdata = '0;
        do_reset();
        check(wrst == 1'b0, 1, 32'(wrst), 32'h0);  // R1

        // vector table
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            unique case (v[73:72])
                OP_WR:   wr(v[71:68], v[67:36]);
                OP_RD:   rd_chk(v[71:68], v[35:4], int'(v[3:0]));
                OP_TICK: ticks(int'(v[67:36]));
                OP_IDLE: repeat (int'(v[67:36])) @(negedge clk);
                default: ;
            endcase
        end

        // R10: the done flag is due one cycle after the accepted write
        unlock16();
        wr(4'h0, 32'h0000_01A0);
        addr = 4'h0;
        #1;
        check(rdata == 32'h0000_01A0, 10, rdata, 32'h0000_01A0);  // R10 not yet
        @(negedge clk);
        #1;
        check(rdata == 32'h0000_05A0, 10, rdata, 32'h0000_05A0);  // R10 now set

        // R13: expiry with timeout 5, count 0
        ticks(4);
        check(wrst == 1'b0, 13, 32'(wrst), 32'h0);          // R13 below limit
        rd_chk(4'h4, 32'd4, 13);                             // R13
        ticks(1);
        check(wrst == 1'b0, 13, 32'(wrst), 32'h0);          // R13 one cycle later
        @(negedge clk);
        check(wrst == 1'b1, 13, 32'(wrst), 32'h1);          // R13 raised
        ticks(3);
        rd_chk(4'h4, 32'd5, 13);                             // R13 count stopped
        wr(4'h4, 32'h0000_A602);
        wr(4'h4, 32'h0000_B480);
        rd_chk(4'h4, 32'd5, 13);                             // R13 refresh too late
        check(wrst == 1'b1, 13, 32'(wrst), 32'h1);          // R13 held

        // R11: sealing the configuration
        do_reset();
        check(wrst == 1'b0, 1, 32'(wrst), 32'h0);           // R1 after reset
        rd_chk(4'h0, 32'h0000_0020, 1);                      // R1
        unlock16();
        wr(4'h0, 32'h0000_0000);
        rd_chk(4'h0, 32'h0000_0400, 11);                     // R11 sealed
        unlock16();
        rd_chk(4'h0, 32'h0000_0400, 11);                     // R11 unlock refused
        wr(4'h8, 32'h0000_0003);
        rd_chk(4'h8, 32'd60000, 11);                         // R11 timeout fixed

        // R11: only reset releases the seal
        do_reset();
        unlock16();
        rd_chk(4'h0, 32'h0000_0820, 11);                     // R11 reopened after reset

        done = 1'b1;
        finish_run();
    end

endmodule